// File: doc/BRIEF.md
# Quad Wiper Register Bank

This block keeps the position state of four digitally set resistor arrays. Each array owns one volatile wiper register, whose low six bits pick the active tap, and four retained position registers that survive a reset and are meant to hold preset positions. A serial front end, outside this block, decodes bus traffic into single-cycle operations. Those operations read or write a wiper, read or write a retained register, or copy between the two. A copy can act on one array or on all four arrays at once with a shared register index.

Retained storage is modelled as flip-flops that reset does not clear. The slow programming time of real retained memory is emulated by a cycle counter. The counter holds a busy flag for a parameterised number of cycles after any retained write. While it runs, the block refuses every operation that would need the retained store, and it reports each refusal. On reset, every wiper is reloaded from retained register 0 of its own array. The tap outputs carry one one-hot field for each array.

Top module: `quad_wiper_bank`

## Requirements
- R1: While rst_n is low at a clock edge, each wiper is loaded from retained register 0 of its array, and busy, rd_valid and op_reject are cleared. Retained registers keep their contents through reset. Their power-on value is 0.
- R2: An accepted op_code 1 writes all 8 bits of op_wdata into the wiper of array op_array. An op_code 0 returns that byte on rd_data, with rd_valid high, in the cycle after the request.
- R3: tap_sel[a*64 + w] is high for exactly one w per array a, where w is bits 5:0 of that array's wiper. Bits 7:6 of the wiper have no effect on tap_sel, and are returned unchanged by reads.
- R4: op_code 3 writes op_wdata into retained register op_reg of array op_array. op_code 2 returns that register one cycle later with rd_valid high. Each of the 16 registers is independent.
- R5: An accepted op_code 3 or op_code 5 raises busy from the next cycle for exactly WRITE_CYCLES cycles.
- R6: op_code 4 with op_global 0 copies retained register op_reg into the wiper of array op_array one cycle later, and does not raise busy. op_code 5 with op_global 0 copies that wiper into the register.
- R7: With op_global 1, op_code 4 and op_code 5 act on all four arrays with the same op_reg, each array using its own registers. op_array is ignored.
- R8: While busy is high, op_code 3, 4 and 5 are rejected: op_reject pulses in the next cycle, and no wiper, retained register or busy window changes.
- R9: While busy is high, op_code 0, 1 and 2 are accepted and behave as when idle.
- R10: op_code 6 and 7 change no state and produce neither rd_valid nor op_reject. op_reject never pulses while busy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Operation request strobe, one cycle per request |
| op_code | input | 3 | Operation: 0 read wiper, 1 write wiper, 2 read retained, 3 write retained, 4 retained to wiper, 5 wiper to retained |
| op_global | input | 1 | Copy acts on all arrays (codes 4 and 5 only) |
| op_array | input | 2 | Array index |
| op_reg | input | 2 | Retained register index |
| op_wdata | input | 8 | Write data |
| rd_data | output | 8 | Read result |
| rd_valid | output | 1 | rd_data holds a read result |
| busy | output | 1 | Retained write in progress |
| op_reject | output | 1 | The previous request was refused because the block was busy |
| tap_sel | output | 256 | One-hot tap enables, 64 per array, array 0 in the low bits |

## Verification
The wiper path is exercised with bytes that differ only in bits 7:6. This shows that the tap decoder ignores those bits while reads still return them. Retained registers are filled with a distinct value for each array and index. Single and global copies can then only pass if the array and index routing is right, and a global copy is distinguished from a single one by checking the arrays that were not named. Requests issued during the busy window are split into those that must be refused and those that must pass. This separates the refusal logic from the read and wiper paths. A reset taken after new values are programmed checks that the wipers reload from the retained store and not from a constant.

// File: rtl/wiper_pkg.sv
// Shared operation codes for the quad wiper register bank.
// Assumes a 3-bit operation field delivered by the serial front end.
package wiper_pkg;
    typedef enum logic [2:0] {
        OP_RD_WIPER = 3'd0,
        OP_WR_WIPER = 3'd1,
        OP_RD_STORE = 3'd2,
        OP_WR_STORE = 3'd3,
        OP_RECALL   = 3'd4,
        OP_SAVE     = 3'd5,
        OP_NOP6     = 3'd6,
        OP_NOP7     = 3'd7
    } wiper_op_e;
endpackage

// File: rtl/tap_decoder.sv
// Tap decoder: turns the low bits of a wiper value into a one-hot enable
// vector. Assumes TAPS == 2**TAP_BITS; upper wiper bits are not looked at.
module tap_decoder #(
    parameter int TAP_BITS = 6,
    parameter int TAPS     = 1 << TAP_BITS
) (
    input  logic [TAP_BITS-1:0] pos,
    output logic [TAPS-1:0]     taps
);
    localparam logic [TAPS-1:0] ONE = {{(TAPS-1){1'b0}}, 1'b1};

    // Shift a single set bit to the selected tap.
    always_comb begin
        taps = ONE << pos;
    end
endmodule

// File: rtl/store_timer.sv
// Retained-write timer: holds busy for WRITE_CYCLES cycles after a start
// pulse. Assumes start is only pulsed while idle; reset cancels the window.
module store_timer #(
    parameter int WRITE_CYCLES = 625000,
    parameter int CNT_W        = $clog2(WRITE_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(WRITE_CYCLES);

    logic [CNT_W-1:0] cnt_q;

    // Load on start, count down to zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (start)
            cnt_q <= LOAD;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    // Busy while the counter has cycles left.
    always_comb begin
        busy = (cnt_q != '0);
    end
endmodule

// File: rtl/wiper_slot.sv
// One array's state: a volatile wiper register and NUM_REGS retained
// registers. Retained registers are not cleared by reset; they power on at
// zero. Reset reloads the wiper from retained register 0. The caller makes
// sure that at most one write enable is high per cycle.
module wiper_slot #(
    parameter int DATA_W   = 8,
    parameter int NUM_REGS = 4,
    parameter int REG_W    = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_wiper,
    input  logic              wr_store,
    input  logic              recall,
    input  logic              save,
    input  logic [REG_W-1:0]  reg_sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] wiper,
    output logic [DATA_W-1:0] store_rd
);
    logic [DATA_W-1:0] wiper_q;
    logic [DATA_W-1:0] store_q [NUM_REGS] = '{default: '0};

    // Wiper register: reset recall, direct write or copy from a stored slot.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wiper_q <= store_q[0];
        else if (wr_wiper)
            wiper_q <= wdata;
        else if (recall)
            wiper_q <= store_q[reg_sel];
    end

    // Retained registers: direct write or save of the current wiper.
    generate
        for (genvar r = 0; r < NUM_REGS; r++) begin : g_store
            always_ff @(posedge clk) begin
                if (rst_n && reg_sel == REG_W'(r)) begin
                    if (wr_store)
                        store_q[r] <= wdata;
                    else if (save)
                        store_q[r] <= wiper_q;
                end
            end
        end
    endgenerate

    // Expose the wiper and the selected retained register.
    always_comb begin
        wiper    = wiper_q;
        store_rd = store_q[reg_sel];
    end
endmodule

// File: rtl/quad_wiper_bank.sv
// Quad wiper register bank: decodes front-end operations, steers them to
// four array slots, runs the retained-write busy window and returns reads
// one cycle after the request. Assumes one op_valid pulse per request.
module quad_wiper_bank
    import wiper_pkg::*;
#(
    parameter int NUM_ARRAYS   = 4,
    parameter int NUM_REGS     = 4,
    parameter int DATA_W       = 8,
    parameter int TAP_BITS     = 6,
    parameter int WRITE_CYCLES = 625000,
    parameter int ARR_W        = $clog2(NUM_ARRAYS),
    parameter int REG_W        = $clog2(NUM_REGS),
    parameter int TAPS         = 1 << TAP_BITS
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       op_valid,
    input  logic [2:0]                 op_code,
    input  logic                       op_global,
    input  logic [ARR_W-1:0]           op_array,
    input  logic [REG_W-1:0]           op_reg,
    input  logic [DATA_W-1:0]          op_wdata,
    output logic [DATA_W-1:0]          rd_data,
    output logic                       rd_valid,
    output logic                       busy,
    output logic                       op_reject,
    output logic [NUM_ARRAYS*TAPS-1:0] tap_sel
);
    wiper_op_e         op;
    logic              needs_idle, accept, is_read, start_store;
    logic [DATA_W-1:0] wiper_v [NUM_ARRAYS];
    logic [DATA_W-1:0] store_v [NUM_ARRAYS];
    logic [DATA_W-1:0] rd_data_q;
    logic              rd_valid_q, reject_q;

    // Classify the request and decide whether it may proceed.
    always_comb begin
        op          = wiper_op_e'(op_code);
        needs_idle  = (op == OP_WR_STORE) || (op == OP_RECALL) || (op == OP_SAVE);
        is_read     = (op == OP_RD_WIPER) || (op == OP_RD_STORE);
        accept      = op_valid && !(needs_idle && busy) &&
                      (op != OP_NOP6) && (op != OP_NOP7);
        start_store = accept && ((op == OP_WR_STORE) || (op == OP_SAVE));
    end

    store_timer #(.WRITE_CYCLES(WRITE_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start_store),
        .busy  (busy)
    );

    generate
        for (genvar a = 0; a < NUM_ARRAYS; a++) begin : g_arr
            logic named, xfer_hit;

            // Direct access follows op_array; copies may be global.
            always_comb begin
                named    = (op_array == ARR_W'(a));
                xfer_hit = named || op_global;
            end

            wiper_slot #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_slot (
                .clk      (clk),
                .rst_n    (rst_n),
                .wr_wiper (accept && op == OP_WR_WIPER && named),
                .wr_store (accept && op == OP_WR_STORE && named),
                .recall   (accept && op == OP_RECALL && xfer_hit),
                .save     (accept && op == OP_SAVE && xfer_hit),
                .reg_sel  (op_reg),
                .wdata    (op_wdata),
                .wiper    (wiper_v[a]),
                .store_rd (store_v[a])
            );

            tap_decoder #(.TAP_BITS(TAP_BITS)) u_dec (
                .pos  (wiper_v[a][TAP_BITS-1:0]),
                .taps (tap_sel[a*TAPS +: TAPS])
            );
        end
    endgenerate

    // Register read results and the refusal flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid_q <= 1'b0;
            reject_q   <= 1'b0;
            rd_data_q  <= '0;
        end else begin
            rd_valid_q <= accept && is_read;
            reject_q   <= op_valid && needs_idle && busy;
            if (accept && is_read)
                rd_data_q <= (op == OP_RD_WIPER) ? wiper_v[op_array] : store_v[op_array];
        end
    end

    // Drive the read and refusal outputs.
    always_comb begin
        rd_data   = rd_data_q;
        rd_valid  = rd_valid_q;
        op_reject = reject_q;
    end
endmodule

// File: rtl/quad_wiper_bank_checker.sv
// Property checker for quad_wiper_bank, attached with bind below.
module quad_wiper_bank_checker #(
    parameter int NUM_ARRAYS = 4,
    parameter int TAPS       = 64
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       op_valid,
    input logic [2:0]                 op_code,
    input logic                       busy,
    input logic                       op_reject,
    input logic                       rd_valid,
    input logic [NUM_ARRAYS*TAPS-1:0] tap_sel
);
    // R1: reset clears the status outputs.
    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (!busy && !rd_valid && !op_reject));

    // R3: one tap per array.
    generate
        for (genvar a = 0; a < NUM_ARRAYS; a++) begin : g_chk
            a_r3_one_tap: assert property (@(posedge clk) disable iff (!rst_n)
                $countones(tap_sel[a*TAPS +: TAPS]) == 1);
        end
    endgenerate

    // R5: an accepted retained write starts the busy window.
    a_r5_busy_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !busy && (op_code == 3'd3 || op_code == 3'd5)) |=> busy);

    // R8: refused requests pulse op_reject and leave the taps alone.
    a_r8_refuse_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && busy && (op_code == 3'd3 || op_code == 3'd4 || op_code == 3'd5))
        |=> (op_reject && $stable(tap_sel)));

    // R9: reads still complete while busy.
    a_r9_read_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && busy && (op_code == 3'd0 || op_code == 3'd2)) |=> rd_valid);

    // R10: unused codes do nothing visible.
    a_r10_unused_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code[2:1] == 2'b11) |=> (!rd_valid && !op_reject && $stable(tap_sel)));

    // R10: a refusal only follows a busy cycle.
    a_r10_reject_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(op_reject) |-> $past(busy));
endmodule

bind quad_wiper_bank quad_wiper_bank_checker #(
    .NUM_ARRAYS (NUM_ARRAYS),
    .TAPS       (TAPS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .op_code   (op_code),
    .busy      (busy),
    .op_reject (op_reject),
    .rd_valid  (rd_valid),
    .tap_sel   (tap_sel)
);

// File: tb/quad_wiper_bank_test.sv
// Directed bench for quad_wiper_bank: one task per scenario.
module quad_wiper_bank_test;
    localparam int W    = 40;
    localparam int TAPS = 64;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         op_valid = 1'b0;
    logic [2:0]   op_code = 3'd0;
    logic         op_global = 1'b0;
    logic [1:0]   op_array = 2'd0;
    logic [1:0]   op_reg = 2'd0;
    logic [7:0]   op_wdata = 8'd0;
    logic [7:0]   rd_data;
    logic         rd_valid, busy, op_reject;
    logic [255:0] tap_sel;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    logic [7:0] exp_w [4];
    logic [7:0] exp_s [4][4];

    quad_wiper_bank #(.WRITE_CYCLES(W)) uut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .op_global(op_global), .op_array(op_array), .op_reg(op_reg),
        .op_wdata(op_wdata), .rd_data(rd_data), .rd_valid(rd_valid),
        .busy(busy), .op_reject(op_reject), .tap_sel(tap_sel)
    );

    always #4 clk = ~clk;

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_op(input logic [2:0] c, input logic g, input logic [1:0] a,
                         input logic [1:0] r, input logic [7:0] d);
        @(negedge clk);
        op_valid = 1'b1; op_code = c; op_global = g; op_array = a; op_reg = r; op_wdata = d;
        @(negedge clk);
        op_valid = 1'b0; op_code = 3'd0; op_global = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic pulse_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Compare every array's wiper (read port and taps) with the model.
    task automatic check_wipers(input string req);
        for (int a = 0; a < 4; a++) begin
            logic [63:0] want;
            do_op(3'd0, 1'b0, 2'(a), 2'd0, 8'd0);
            check(rd_valid && rd_data == exp_w[a], req, {55'd0, rd_valid, rd_data}, {56'd1, exp_w[a]});
            want = 64'd1 << exp_w[a][5:0];
            check(tap_sel[a*TAPS +: TAPS] == want, req, tap_sel[a*TAPS +: TAPS], want);
        end
    endtask

    task automatic check_store(input int a, input int r, input string req);
        do_op(3'd2, 1'b0, 2'(a), 2'(r), 8'd0);
        check(rd_valid && rd_data == exp_s[a][r], req, {55'd0, rd_valid, rd_data}, {56'd1, exp_s[a][r]});
    endtask

    task automatic t_reset_state();
        check(!busy && !rd_valid && !op_reject, "R1 flags", {busy, rd_valid, op_reject}, 0);
        check_wipers("R1 power-on recall");
    endtask

    task automatic t_wiper_rw();
        do_op(3'd1, 1'b0, 2'd2, 2'd0, 8'hC5); exp_w[2] = 8'hC5;
        do_op(3'd1, 1'b0, 2'd0, 2'd0, 8'h3F); exp_w[0] = 8'h3F;
        check_wipers("R2 wiper write/read");
    endtask

    task automatic t_tap_upper_bits();
        do_op(3'd1, 1'b0, 2'd1, 2'd0, 8'h05); exp_w[1] = 8'h05;
        check_wipers("R3 tap position 5");
        do_op(3'd1, 1'b0, 2'd1, 2'd0, 8'hC5); exp_w[1] = 8'hC5;
        check_wipers("R3 upper bits ignored by taps");
    endtask

    task automatic t_store_rw();
        for (int a = 0; a < 4; a++)
            for (int r = 0; r < 4; r++) begin
                exp_s[a][r] = 8'((a << 4) | (r << 2) | 8'h81);
                do_op(3'd3, 1'b0, 2'(a), 2'(r), exp_s[a][r]);
                wait_idle();
            end
        for (int a = 0; a < 4; a++)
            for (int r = 0; r < 4; r++) check_store(a, r, "R4 retained read");
    endtask

    task automatic t_single_copy();
        do_op(3'd4, 1'b0, 2'd3, 2'd2, 8'd0); exp_w[3] = exp_s[3][2];
        check(!busy, "R6 recall no busy", busy, 0);
        check_wipers("R6 single recall");
        do_op(3'd1, 1'b0, 2'd1, 2'd0, 8'h6A); exp_w[1] = 8'h6A;
        do_op(3'd5, 1'b0, 2'd1, 2'd3, 8'd0); exp_s[1][3] = 8'h6A;
        wait_idle();
        for (int a = 0; a < 4; a++) check_store(a, 3, "R6 single save");
    endtask

    task automatic t_global_copy();
        do_op(3'd4, 1'b1, 2'd0, 2'd1, 8'd0);
        for (int a = 0; a < 4; a++) exp_w[a] = exp_s[a][1];
        check_wipers("R7 global recall");
        for (int a = 0; a < 4; a++) begin
            do_op(3'd1, 1'b0, 2'(a), 2'd0, 8'(8'h10 + a)); exp_w[a] = 8'(8'h10 + a);
        end
        do_op(3'd5, 1'b1, 2'd2, 2'd0, 8'd0);
        for (int a = 0; a < 4; a++) exp_s[a][0] = exp_w[a];
        wait_idle();
        for (int a = 0; a < 4; a++) check_store(a, 0, "R7 global save");
    endtask

    task automatic t_busy_window();
        int cnt = 0;
        do_op(3'd3, 1'b0, 2'd0, 2'd2, 8'h5A); exp_s[0][2] = 8'h5A;
        while (busy && cnt < W + 5) begin cnt++; @(negedge clk); end
        check(cnt == W, "R5 busy length", cnt, W);
    endtask

    task automatic t_busy_refuse_and_allow();
        do_op(3'd5, 1'b0, 2'd2, 2'd3, 8'd0); exp_s[2][3] = exp_w[2];
        check(busy, "R5 busy after save", busy, 1);
        do_op(3'd3, 1'b0, 2'd2, 2'd3, 8'hEE);
        check(op_reject, "R8 store write refused", op_reject, 1);
        do_op(3'd4, 1'b1, 2'd0, 2'd2, 8'd0);
        check(op_reject, "R8 recall refused", op_reject, 1);
        do_op(3'd5, 1'b0, 2'd1, 2'd1, 8'd0);
        check(op_reject, "R8 save refused", op_reject, 1);
        do_op(3'd1, 1'b0, 2'd0, 2'd0, 8'h77); exp_w[0] = 8'h77;
        check(!op_reject && busy, "R9 wiper write in busy", {op_reject, busy}, 1);
        check_store(2, 3, "R9 read in busy / R8 unchanged");
        check_wipers("R8 R9 wipers during busy");
        wait_idle();
        check_store(1, 1, "R8 refused save left register");
        check_store(2, 3, "R8 refused write left register");
    endtask

    task automatic t_unused_codes();
        do_op(3'd6, 1'b1, 2'd1, 2'd1, 8'hFF);
        check(!rd_valid && !op_reject && !busy, "R10 code 6", {rd_valid, op_reject, busy}, 0);
        do_op(3'd7, 1'b0, 2'd3, 2'd0, 8'hFF);
        check(!rd_valid && !op_reject && !busy, "R10 code 7", {rd_valid, op_reject, busy}, 0);
        check_wipers("R10 wipers untouched");
        check_store(3, 0, "R10 register untouched");
    endtask

    task automatic t_reset_recall();
        do_op(3'd1, 1'b0, 2'd3, 2'd0, 8'h01); exp_w[3] = 8'h01;
        do_op(3'd3, 1'b0, 2'd3, 2'd0, 8'hA9); exp_s[3][0] = 8'hA9;
        pulse_reset();
        for (int a = 0; a < 4; a++) exp_w[a] = exp_s[a][0];
        @(negedge clk);
        check(!busy, "R1 reset cancels busy", busy, 0);
        check_wipers("R1 reset recall");
        for (int r = 0; r < 4; r++) check_store(3, r, "R1 retained across reset");
    endtask

    initial begin
        for (int a = 0; a < 4; a++) begin
            exp_w[a] = 8'd0;
            for (int r = 0; r < 4; r++) exp_s[a][r] = 8'd0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_wiper_rw();
        t_tap_upper_bits();
        t_store_rw();
        t_single_copy();
        t_global_copy();
        t_busy_window();
        t_busy_refuse_and_allow();
        t_unused_codes();
        t_reset_recall();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++; n_fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end
endmodule